// File: doc/BRIEF.md
# Frame Buffer Scan-Out Read Streamer

This block feeds a display pipeline from a double-buffered frame store in memory. It walks a raster position across the whole visible frame, left to right and top to bottom. For each position it issues one single-beat, 4-byte read on an AXI4 read address channel, aimed at whichever of the two frame buffers is selected for display. Each 32-bit read response is split into an alpha/red/green/blue pixel and written into a display FIFO.

Requests are throttled by the FIFO's room indication. A new read address is offered only while the FIFO can take more pixels, so the memory port is not claimed every cycle. The raster position moves forward only when the address channel accepts a request. The buffer-select input is registered before it is used, so software-side flips take effect at a clean request boundary.

Top module: `scan_fb_reader`

## Requirements
- R1: Every read request carries arlen = 0 (one transfer), arsize = 2 (4 bytes) and arburst = 2'b00 (FIXED).
- R2: arvalid rises only in a cycle after one in which fifo_room was 1. While fifo_room stays 0 and no request is pending, arvalid stays 0.
- R3: While arvalid = 1 and arready = 0, arvalid stays 1 and araddr keeps its value into the next cycle.
- R4: The raster position advances by exactly one step per accepted request (arvalid = 1 and arready = 1 in the same cycle), and at no other time.
- R5: Positions run x = 0..FRAME_W-1 within a row, then move to the next row. After (FRAME_W-1, FRAME_H-1) they return to (0, 0).
- R6: rready equals fifo_room. pix_we is 1 exactly when rvalid = 1 and fifo_room = 1, so a response offered with no room is not written.
- R7: On a write, pix_alpha = rdata[7:0], pix_red = rdata[15:8], pix_green = rdata[23:16] and pix_blue = rdata[31:24].
- R8: araddr = BASE_ADDR + sel * FRAME_W * FRAME_H * 4 + (y * FRAME_W + x) * 4. Here sel is 0 for the first buffer and 1 for the second.
- R9: disp_sel is sampled into a register every cycle, and a request takes its buffer from that register only when it is loaded. A change of disp_sel while a request is pending does not alter that request.
- R10: After synchronous reset (rst = 1) the position is (0, 0) and arvalid is 0. The first request after reset addresses pixel (0, 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_sel | input | 1 | Frame buffer chosen for display (0 or 1) |
| fifo_room | input | 1 | Display FIFO can accept a pixel |
| araddr | output | ADDR_W | Read address |
| arlen | output | 8 | Burst length minus one (always 0) |
| arsize | output | 3 | Bytes per beat as a power of two (always 2) |
| arburst | output | 2 | Burst type (always FIXED) |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address accepted |
| rdata | input | 32 | Read response data |
| rvalid | input | 1 | Read response valid |
| rready | output | 1 | Read response ready |
| pix_we | output | 1 | Pixel write strobe to the FIFO |
| pix_alpha | output | 8 | Alpha byte |
| pix_red | output | 8 | Red byte |
| pix_green | output | 8 | Green byte |
| pix_blue | output | 8 | Blue byte |

## Verification
The properties assume that the memory side obeys the AXI4 handshake. arready may be held low for any number of cycles, but a response is only presented after its request and is held with rvalid until rready takes it. The bench's address-channel model drives arready from a random pattern. Its response model keeps rvalid and rdata steady until the beat is accepted. Buffer-select changes are made either with no request in flight, or deliberately while a request is stalled, so that the property on held requests is exercised under a select flip.

// File: rtl/scanout_pkg.sv
package scanout_pkg;

    // AXI4 burst type encodings
    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10
    } burst_e;

    // One 32-bit response word: byte 0 alpha, byte 1 red, byte 2 green, byte 3 blue
    typedef struct packed {
        logic [7:0] blue;
        logic [7:0] green;
        logic [7:0] red;
        logic [7:0] alpha;
    } pixel_t;

    localparam logic [7:0] SINGLE_BEAT_LEN = 8'd0;
    localparam logic [2:0] WORD_SIZE_CODE  = 3'd2;
    localparam int         BYTES_PER_PIX   = 4;

endpackage

// File: rtl/scan_raster_walker.sv
module scan_raster_walker #(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480,
    parameter int X_W     = $clog2(FRAME_W),
    parameter int Y_W     = $clog2(FRAME_H)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    output logic [X_W-1:0] nxt_x,
    output logic [Y_W-1:0] nxt_y
);

    localparam logic [X_W-1:0] X_LAST = X_W'(FRAME_W - 1);
    localparam logic [Y_W-1:0] Y_LAST = Y_W'(FRAME_H - 1);

    typedef struct packed {
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (step) begin
            if (pos_q.x == X_LAST) begin
                pos_d.x = '0;
                if (pos_q.y == Y_LAST) begin
                    pos_d.y = '0;
                end else begin
                    pos_d.y = pos_q.y + 1'b1;
                end
            end else begin
                pos_d.x = pos_q.x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    // Position after this cycle's optional step, used to load the next request
    assign nxt_x = pos_d.x;
    assign nxt_y = pos_d.y;

    // R4: no accepted request, no movement
    a_r4_hold_still: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos_q));

    // R5: the last pixel of the frame wraps to the origin
    a_r5_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && pos_q.x == X_LAST && pos_q.y == Y_LAST) |=> (pos_q.x == '0 && pos_q.y == '0));

    // R5: the end of a row moves to column zero of the next row
    a_r5_row_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && pos_q.x == X_LAST && pos_q.y != Y_LAST) |=> (pos_q.x == '0 && pos_q.y == $past(pos_q.y) + 1'b1));

endmodule

// File: rtl/scan_req_issuer.sv
module scan_req_issuer #(
    parameter int          FRAME_W   = 640,
    parameter int          FRAME_H   = 480,
    parameter int          ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int          X_W       = $clog2(FRAME_W),
    parameter int          Y_W       = $clog2(FRAME_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_sel,
    input  logic              fifo_room,
    input  logic              arready,
    input  logic [X_W-1:0]    nxt_x,
    input  logic [Y_W-1:0]    nxt_y,
    output logic              step,
    output logic              arvalid,
    output logic [ADDR_W-1:0] araddr
);
    import scanout_pkg::*;

    localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(FRAME_W * FRAME_H * BYTES_PER_PIX);
    localparam logic [ADDR_W-1:0] WIDTH_A     = ADDR_W'(FRAME_W);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              sel;
    } req_t;

    req_t req_d, req_q;

    function automatic logic [ADDR_W-1:0] pix_addr(
        input logic           s,
        input logic [X_W-1:0] x,
        input logic [Y_W-1:0] y
    );
        logic [ADDR_W-1:0] lin;
        logic [ADDR_W-1:0] base;
        lin  = ADDR_W'(y) * WIDTH_A + ADDR_W'(x);
        base = s ? (BASE_ADDR + FRAME_BYTES) : BASE_ADDR;
        return base + (lin << 2);
    endfunction

    logic slot_free;

    always_comb begin
        req_d     = req_q;
        req_d.sel = disp_sel;
        step      = req_q.valid & arready;
        slot_free = ~req_q.valid | arready;
        if (slot_free) begin
            req_d.valid = fifo_room;
            req_d.addr  = pix_addr(req_q.sel, nxt_x, nxt_y);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q.valid <= 1'b0;
            req_q.addr  <= BASE_ADDR;
            req_q.sel   <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign arvalid = req_q.valid;
    assign araddr  = req_q.addr;

    // R2: a new request appears only after the FIFO reported room
    a_r2_room_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(arvalid) |-> $past(fifo_room));

    // R3, R9: a stalled request keeps valid and address
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (arvalid && !arready) |=> (arvalid && $stable(araddr)));

    // R8: every request lands inside one of the two frame regions
    a_r8_in_region: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> (araddr >= BASE_ADDR && araddr < BASE_ADDR + (FRAME_BYTES << 1)));

endmodule

// File: rtl/scan_resp_unpacker.sv
module scan_resp_unpacker (
    input  logic                  fifo_room,
    input  logic                  rvalid,
    input  logic [31:0]           rdata,
    output logic                  rready,
    output logic                  pix_we,
    output scanout_pkg::pixel_t   pix
);
    always_comb begin
        rready = fifo_room;
        pix_we = rvalid & fifo_room;
        pix    = scanout_pkg::pixel_t'(rdata);
    end

endmodule

// File: rtl/scan_fb_reader.sv
module scan_fb_reader #(
    parameter int          FRAME_W   = 640,
    parameter int          FRAME_H   = 480,
    parameter int          ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_sel,
    input  logic              fifo_room,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    output logic              arvalid,
    input  logic              arready,
    input  logic [31:0]       rdata,
    input  logic              rvalid,
    output logic              rready,
    output logic              pix_we,
    output logic [7:0]        pix_alpha,
    output logic [7:0]        pix_red,
    output logic [7:0]        pix_green,
    output logic [7:0]        pix_blue
);
    import scanout_pkg::*;

    localparam int X_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int Y_W = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;

    logic           step;
    logic [X_W-1:0] nxt_x;
    logic [Y_W-1:0] nxt_y;
    pixel_t         pix;

    scan_raster_walker #(
        .FRAME_W (FRAME_W),
        .FRAME_H (FRAME_H),
        .X_W     (X_W),
        .Y_W     (Y_W)
    ) u_walker (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .nxt_x (nxt_x),
        .nxt_y (nxt_y)
    );

    scan_req_issuer #(
        .FRAME_W   (FRAME_W),
        .FRAME_H   (FRAME_H),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .X_W       (X_W),
        .Y_W       (Y_W)
    ) u_issuer (
        .clk       (clk),
        .rst       (rst),
        .disp_sel  (disp_sel),
        .fifo_room (fifo_room),
        .arready   (arready),
        .nxt_x     (nxt_x),
        .nxt_y     (nxt_y),
        .step      (step),
        .arvalid   (arvalid),
        .araddr    (araddr)
    );

    scan_resp_unpacker u_unpacker (
        .fifo_room (fifo_room),
        .rvalid    (rvalid),
        .rdata     (rdata),
        .rready    (rready),
        .pix_we    (pix_we),
        .pix       (pix)
    );

    // R1: single 4-byte beat, fixed burst
    assign arlen     = SINGLE_BEAT_LEN;
    assign arsize    = WORD_SIZE_CODE;
    assign arburst   = BURST_FIXED;

    assign pix_alpha = pix.alpha;
    assign pix_red   = pix.red;
    assign pix_green = pix.green;
    assign pix_blue  = pix.blue;

endmodule

// File: tb/tb_scan_fb_reader.sv
`timescale 1ns/1ps
module tb_scan_fb_reader;

    localparam int W  = 16;
    localparam int H  = 8;
    localparam int AW = 32;
    localparam logic [AW-1:0] BASE = 32'h0010_0000;

    logic          clk = 0;
    logic          rst = 1;
    logic          disp_sel = 0;
    logic          fifo_room = 0;
    logic          arready = 0;
    logic [31:0]   rdata = '0;
    logic          rvalid = 0;
    logic [AW-1:0] araddr;
    logic [7:0]    arlen;
    logic [2:0]    arsize;
    logic [1:0]    arburst;
    logic          arvalid, rready, pix_we;
    logic [7:0]    pix_alpha, pix_red, pix_green, pix_blue;

    always #5 clk = ~clk;

    scan_fb_reader #(.FRAME_W(W), .FRAME_H(H), .ADDR_W(AW), .BASE_ADDR(BASE)) dut (
        .clk(clk), .rst(rst), .disp_sel(disp_sel), .fifo_room(fifo_room),
        .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .arvalid(arvalid), .arready(arready), .rdata(rdata), .rvalid(rvalid),
        .rready(rready), .pix_we(pix_we), .pix_alpha(pix_alpha), .pix_red(pix_red),
        .pix_green(pix_green), .pix_blue(pix_blue)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive modes: room 0=off 1=on 2=random ; ready 0=low 1=high 2=random
    int room_mode = 0;
    int rdy_mode  = 0;
    always @(posedge clk) begin
        #1;
        case (room_mode)
            0: fifo_room = 0;
            1: fifo_room = 1;
            default: fifo_room = ($urandom % 4) != 0;
        endcase
        case (rdy_mode)
            0: arready = 0;
            1: arready = 1;
            default: arready = ($urandom % 3) != 0;
        endcase
    end

    // Address model (R4, R5, R8)
    int  mx = 0, my = 0;
    bit  msel = 0;
    int  hs_count = 0;
    function automatic logic [AW-1:0] exp_addr(input bit s, input int x, input int y);
        return BASE + (s ? AW'(W*H*4) : '0) + AW'((y*W + x)*4);
    endfunction

    // Pixel scoreboard queue (R6, R7)
    logic [31:0] pix_q[$];
    int rr_mismatch = 0;

    logic          p_av = 0, p_ar = 0, p_room = 0;
    logic [AW-1:0] p_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (arvalid && arready) begin
                check(araddr == exp_addr(msel, mx, my), "R4/R5/R8 address order", araddr, exp_addr(msel, mx, my));
                check(arlen == 8'd0 && arsize == 3'd2 && arburst == 2'b00, "R1 request fields",
                      {arlen, arsize, arburst}, {8'd0, 3'd2, 2'b00});
                hs_count++;
                mx++;
                if (mx == W) begin
                    mx = 0;
                    my++;
                    if (my == H) my = 0;
                end
            end
            if (p_av && !p_ar)
                check(arvalid && araddr == p_addr, "R3 stalled request held", {arvalid, araddr}, {1'b1, p_addr});
            if (arvalid && !p_av)
                check(p_room, "R2 request rose without room", p_room, 1);
            if (rready != fifo_room) rr_mismatch++;
            if (pix_we) begin
                if (pix_q.size() == 0) begin
                    check(0, "R6 unexpected pixel write", 1, 0);
                end else begin
                    logic [31:0] e;
                    e = pix_q.pop_front();
                    check({pix_blue, pix_green, pix_red, pix_alpha} == e, "R7 byte mapping",
                          {pix_blue, pix_green, pix_red, pix_alpha}, e);
                end
                check(rvalid && fifo_room, "R6 write without accepted beat", {rvalid, fifo_room}, 2'b11);
            end else if (rvalid && fifo_room) begin
                check(0, "R6 accepted beat not written", 0, 1);
            end
            p_av = arvalid; p_ar = arready; p_room = fifo_room; p_addr = araddr;
        end
    end

    // Response driver: pushes expected pixel, holds beat until accepted
    task automatic send_beat(input logic [31:0] d);
        pix_q.push_back(d);
        @(posedge clk); #2;
        rvalid = 1; rdata = d;
        do @(negedge clk); while (!fifo_room);
        @(posedge clk); #2;
        rvalid = 0;
    endtask

    task automatic wait_hs(input int n);
        while (hs_count < n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", hs_count, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        check(arvalid == 0, "R10 arvalid clear after reset", arvalid, 0);
        check(rready == 0 && pix_we == 0, "R6 no ready without room", {rready, pix_we}, 0);
        repeat (6) @(negedge clk);
        check(arvalid == 0, "R2 no request while FIFO full", arvalid, 0);

        // Full frame plus wrap, random stalls on both sides, buffer 0
        room_mode = 2; rdy_mode = 2;
        fork
            wait_hs(W*H + 12);
            for (int i = 0; i < 30; i++) send_beat($urandom);
        join
        check(hs_count >= W*H + 12, "R5 frame wrap reached", hs_count, W*H + 12);

        // Quiesce, then verify no requests without room
        @(negedge clk); room_mode = 0; rdy_mode = 1;
        repeat (6) @(negedge clk);
        check(arvalid == 0, "R2 idle with no room", arvalid, 0);

        // R9: flip select while a request is stalled
        room_mode = 1; rdy_mode = 0;
        while (!arvalid) @(negedge clk);
        p_addr = araddr;
        disp_sel = 1;
        repeat (4) @(negedge clk);
        check(araddr == exp_addr(0, mx, my), "R9 pending request keeps old buffer", araddr, exp_addr(0, mx, my));
        room_mode = 0; rdy_mode = 1;
        repeat (5) @(negedge clk);
        msel = 1;

        // Second buffer, R8
        room_mode = 1; rdy_mode = 2;
        begin
            int target;
            target = hs_count + 20;
            wait_hs(target);
        end

        // R6: beat offered with no room is not written
        @(negedge clk); room_mode = 0; rdy_mode = 1;
        repeat (4) @(negedge clk);
        fork
            send_beat(32'hA1B2C3D4);
            begin
                repeat (5) @(negedge clk);
                check(pix_we == 0 && rvalid == 1, "R6 beat ignored without room", {pix_we, rvalid}, 2'b01);
                check(pix_q.size() == 1, "R6 pixel still pending", pix_q.size(), 1);
                room_mode = 1; rdy_mode = 0;
            end
        join
        repeat (3) @(negedge clk);
        check(pix_q.size() == 0, "R7 pending pixel delivered", pix_q.size(), 0);

        // Back to buffer 0 with stable traffic
        room_mode = 0; rdy_mode = 1;
        repeat (6) @(negedge clk);
        disp_sel = 0;
        repeat (4) @(negedge clk);
        msel = 0;
        room_mode = 1; rdy_mode = 1;
        begin
            int target;
            target = hs_count + W*H;
            fork
                wait_hs(target);
                for (int i = 0; i < 12; i++) send_beat({8'(i), 8'(i+64), 8'(i+128), 8'(255-i)});
            join
        end
        @(negedge clk); room_mode = 0;
        repeat (4) @(negedge clk);
        check(rr_mismatch == 0, "R6 rready follows fifo_room", rr_mismatch, 0);
        check(pix_q.size() == 0, "R7 scoreboard drained", pix_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end

endmodule